// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a register-mapped SPI master for a simple single-cycle register bus. Software pushes command bytes into a transmit FIFO, programs how many bytes the whole burst lasts and how many of them are taken from the transmit FIFO, and then sets an exchange bit. The controller drives one active-low chip select, clocks the transmit bytes out and pads the rest of the burst with dummy bytes. It keeps every byte that arrives on the serial input, including the ones that arrive while the command is still going out.

A typical flash read loads a four-byte command and address, sets the burst to four plus the data length, and sets the transmit length to four. Software then polls the exchange bit, drops the first four received bytes and keeps the rest. The block has one chip select, works only in SPI mode 0 (clock idles low, data sampled on the rising edge, MSB first), and offers two SCK rates derived from its clock.

Register map (word addresses on `bus_addr`): 0 control, 1 transmit data (write), 2 receive data (read, pops), 3 burst byte count, 4 transmit byte count, 5 clock setting, 6 FIFO status.

Top module: `spi_burst_master`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, and the control, burst count, transmit count, clock setting and status registers all read 0.
- R2: A write to control (address 0) with bit 10 set, bit 0 (enable) and bit 1 (master) set and a nonzero burst count starts a burst; bit 10 reads 1 from the next cycle until the burst ends and 0 afterwards; bits 0 and 1 read back as written. Without both enable and master the exchange write has no effect and the chip select stays high.
- R3: A burst clocks exactly burst-count bytes: the first transmit-count bytes come from the transmit FIFO in write order, all later bytes are dummy 0xFF, and a transmit-phase byte needed while the FIFO is empty is sent as 0xFF.
- R4: Every byte received during a burst, command phase included, is pushed into the receive FIFO in arrival order and read from address 2.
- R5: Data is MSB first in mode 0: SCK idles low, MOSI does not change at a rising SCK edge, and the receiver sees each transmitted byte intact.
- R6: Chip select falls at least half an SCK period before the first rising SCK edge, stays low for the whole burst (one low pulse per burst), and rises after the last falling SCK edge.
- R7: Clock setting bit 0 = 0 (reset value) gives an SCK period of 4 clock cycles; bit 0 = 1 gives 2 clock cycles.
- R8: Each FIFO holds 64 bytes; status bits [6:0] give the receive FIFO level and bits [14:8] the transmit FIFO level.
- R9: Writing control bit 8 empties the transmit FIFO and bit 9 empties the receive FIFO; both bits read back 0.
- R10: Writing control bit 15 (soft reset) empties both FIFOs, clears the burst and transmit counts and stops any burst; the bit clears itself on the next cycle.
- R11: A transmit data write while the transmit FIFO is full is ignored, and a receive data read while the receive FIFO is empty returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 2) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in |

## Verification
On every cycle the assertions hold the framing rules: SCK only runs under an active chip select, MOSI stays put across a rising edge, received bytes are pushed only inside a burst, the chip select is released when the trailing half period ends, and neither FIFO overflows. They also check that a push to a full FIFO leaves its level unchanged, that a flush empties it, that an accepted exchange makes the block busy, and that an empty receive read returns zero. Byte content and counts cannot be seen by a property: the command/dummy split, the receive stream in order, the measured SCK period for each clock setting, and the effect of flushes and soft reset on the register values are shown only by the bench's directed scenarios against a slave model.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  // register word addresses
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_TXD    = 3'd1;
  localparam logic [2:0] A_RXD    = 3'd2;
  localparam logic [2:0] A_BURST  = 3'd3;
  localparam logic [2:0] A_XMIT   = 3'd4;
  localparam logic [2:0] A_CLKCFG = 3'd5;
  localparam logic [2:0] A_STAT   = 3'd6;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_MST   = 1;
  localparam int B_TXRST = 8;
  localparam int B_RXRST = 9;
  localparam int B_XCH   = 10;
  localparam int B_SRST  = 15;

  typedef enum logic [1:0] {
    E_IDLE,
    E_LEAD,
    E_SHIFT,
    E_TRAIL
  } eng_state_e;

  // module clock cycles per SCK half period
  function automatic logic [2:0] half_ticks(input logic fast);
    return fast ? 3'd1 : 3'd2;
  endfunction

  // byte to shift out next
  function automatic logic [7:0] pick_byte(input logic from_tx,
                                           input logic [7:0] txd,
                                           input logic [7:0] dummy);
    return from_tx ? txd : dummy;
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R8: the level never passes the depth
  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R11: a push into a full FIFO leaves the level where it was
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)));

  // R9: a flush always leaves the FIFO empty
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int          CW    = 16,
  parameter logic [7:0]  DUMMY = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          fast,
  input  logic [CW-1:0] burst_len,
  input  logic [CW-1:0] tx_len,
  input  logic          tx_empty,
  input  logic [7:0]    tx_data,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_byte,
  output logic          busy,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  eng_state_e     state_q;
  logic [2:0]     div_q;
  logic [2:0]     bit_q;
  logic [CW-1:0]  left_q;
  logic [CW-1:0]  txl_q;
  logic [7:0]     out_q;
  logic [7:0]     in_q;
  logic           sck_q;
  logic           cs_q;

  // named internal events
  logic           tick;
  logic           running;
  logic           rise_ev;
  logic           fall_ev;
  logic           byte_done;
  logic           last_byte;
  logic           launch;
  logic           load_now;
  logic           use_tx;
  logic [CW-1:0]  txl_src;

  assign running   = (state_q != E_IDLE);
  assign tick      = running && (div_q == half_ticks(fast) - 3'd1);
  assign rise_ev   = tick && !sck_q && (state_q == E_LEAD || state_q == E_SHIFT);
  assign fall_ev   = tick && sck_q && (state_q == E_SHIFT);
  assign byte_done = fall_ev && (bit_q == 3'd7);
  assign last_byte = (left_q == CW'(1));
  assign launch    = (state_q == E_IDLE) && start && (burst_len != '0);
  assign load_now  = launch || (byte_done && !last_byte);
  assign txl_src   = (state_q == E_IDLE) ? tx_len : txl_q;
  assign use_tx    = load_now && (txl_src != '0) && !tx_empty;

  assign tx_pop = use_tx;
  assign busy   = running;
  assign sck    = sck_q;
  assign cs_n   = cs_q;
  assign mosi   = cs_q ? 1'b0 : out_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= E_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      txl_q   <= '0;
      out_q   <= '0;
      in_q    <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      rx_push <= 1'b0;
      rx_byte <= '0;
    end else if (abort) begin
      state_q <= E_IDLE;
      div_q   <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (running) div_q <= tick ? 3'd0 : div_q + 3'd1;
      if (load_now) begin
        out_q <= pick_byte(use_tx, tx_data, DUMMY);
        if (txl_src != '0) txl_q <= txl_src - CW'(1);
        else               txl_q <= '0;
        bit_q <= '0;
      end
      case (state_q)
        E_IDLE: begin
          if (launch) begin
            cs_q    <= 1'b0;
            div_q   <= '0;
            left_q  <= burst_len;
            state_q <= E_LEAD;
          end
        end
        E_LEAD, E_SHIFT: begin
          if (rise_ev) begin
            sck_q   <= 1'b1;
            in_q    <= {in_q[6:0], miso};
            state_q <= E_SHIFT;
          end
          if (fall_ev) begin
            sck_q <= 1'b0;
            if (byte_done) begin
              rx_push <= 1'b1;
              rx_byte <= in_q;
              left_q  <= left_q - CW'(1);
              if (last_byte) state_q <= E_TRAIL;
            end else begin
              bit_q <= bit_q + 3'd1;
              out_q <= {out_q[6:0], 1'b0};
            end
          end
        end
        E_TRAIL: begin
          if (tick) begin
            cs_q    <= 1'b1;
            state_q <= E_IDLE;
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  // R6: SCK only runs while the chip select is active
  p_sck_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  // R5: MOSI holds still across a rising SCK edge
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R4: received bytes are only delivered inside a burst
  p_push_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !cs_n);

  // R6: the chip select is released when the trailing half period ends
  p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n || abort)
    (state_q == E_TRAIL && tick) |=> cs_n);

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int          DEPTH = 64,
  parameter int          CW    = 16,
  parameter logic [7:0]  DUMMY = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic          en_q, mst_q, srst_q, fast_q;
  logic [CW-1:0] burst_q, xmit_q;

  logic          wr_ctrl, xch_start, tx_flush, rx_flush, tx_push, rx_pop;
  logic          busy, eng_tx_pop, eng_rx_push;
  logic [7:0]    eng_rx_byte, tx_head, rx_head;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[7:2], bus_wdata[14:11], rx_full};

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign xch_start = wr_ctrl && bus_wdata[B_XCH] && bus_wdata[B_EN] &&
                     bus_wdata[B_MST] && (burst_q != '0) && !busy && !srst_q;
  assign tx_flush  = srst_q || (wr_ctrl && bus_wdata[B_TXRST]);
  assign rx_flush  = srst_q || (wr_ctrl && bus_wdata[B_RXRST]);
  assign tx_push   = bus_wr && (bus_addr == A_TXD);
  assign rx_pop    = bus_rd && (bus_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      srst_q  <= 1'b0;
      fast_q  <= 1'b0;
      burst_q <= '0;
      xmit_q  <= '0;
    end else begin
      srst_q <= wr_ctrl && bus_wdata[B_SRST];
      if (wr_ctrl) begin
        en_q  <= bus_wdata[B_EN];
        mst_q <= bus_wdata[B_MST];
      end
      if (bus_wr && bus_addr == A_CLKCFG) fast_q <= bus_wdata[0];
      if (srst_q) begin
        burst_q <= '0;
        xmit_q  <= '0;
      end else begin
        if (bus_wr && bus_addr == A_BURST) burst_q <= bus_wdata[CW-1:0];
        if (bus_wr && bus_addr == A_XMIT)  xmit_q  <= bus_wdata[CW-1:0];
      end
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (tx_push),
    .wdata (bus_wdata[7:0]),
    .pop   (eng_tx_pop),
    .rdata (tx_head),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (eng_rx_push),
    .wdata (eng_rx_byte),
    .pop   (rx_pop),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  spi_shift_engine #(.CW(CW), .DUMMY(DUMMY)) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xch_start),
    .abort     (srst_q),
    .fast      (fast_q),
    .burst_len (burst_q),
    .tx_len    (xmit_q),
    .tx_empty  (tx_empty),
    .tx_data   (tx_head),
    .tx_pop    (eng_tx_pop),
    .rx_push   (eng_rx_push),
    .rx_byte   (eng_rx_byte),
    .busy      (busy),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_EN]   = en_q;
        bus_rdata[B_MST]  = mst_q;
        bus_rdata[B_XCH]  = busy;
        bus_rdata[B_SRST] = srst_q;
      end
      A_RXD:    bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      A_BURST:  bus_rdata = 16'(burst_q);
      A_XMIT:   bus_rdata = 16'(xmit_q);
      A_CLKCFG: bus_rdata[0] = fast_q;
      A_STAT: begin
        bus_rdata[LW-1:0]  = rx_level;
        bus_rdata[8 +: LW] = tx_level;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R2: an accepted exchange write makes the block busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xch_start |=> busy);

  // R11: an empty receive FIFO reads as zero
  p_empty_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && rx_empty) |-> (bus_rdata == 16'h0000));

  // R1/R6: with no burst running the chip select is inactive
  p_idle_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> spi_cs_n);

endmodule

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- slave model ----------------
  function automatic logic [7:0] resp(input int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  logic [7:0] cap [0:127];
  logic [7:0] s_out = 8'h00, s_in = 8'h00;
  int   s_bits = 0, s_nbyte = 0, cs_falls = 0, sck_rise_no_cs = 0;
  logic sck_prev = 1'b0, cs_prev = 1'b1;
  bit   first_pending = 0;
  realtime t_cs_fall = 0, t_cs_rise = 0, t_first_rise = 0, t_last_fall = 0;
  realtime t_prev_rise = 0, sck_period = 0;

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n !== cs_prev) begin
      if (spi_cs_n === 1'b0) begin
        cs_falls++;
        t_cs_fall = $realtime;
        first_pending = 1;
        s_nbyte = 0;
        s_bits = 0;
        s_out = resp(0);
        spi_miso = s_out[7];
      end else begin
        t_cs_rise = $realtime;
      end
    end
    if (spi_sck !== sck_prev) begin
      if (spi_sck === 1'b1) begin
        if (spi_cs_n !== 1'b0) sck_rise_no_cs++;
        if (first_pending) begin
          t_first_rise = $realtime;
          first_pending = 0;
        end
        sck_period = $realtime - t_prev_rise;
        t_prev_rise = $realtime;
        s_in = {s_in[6:0], spi_mosi};
        s_bits++;
        if (s_bits == 8) begin
          if (s_nbyte < 128) cap[s_nbyte] = s_in;
          s_nbyte++;
          s_bits = 0;
        end
      end else begin
        t_last_fall = $realtime;
        if (spi_cs_n === 1'b0) begin
          if (s_bits == 0) s_out = resp(s_nbyte);
          else             s_out = {s_out[6:0], 1'b0};
          spi_miso = s_out[7];
        end
      end
    end
    sck_prev = spi_sck;
    cs_prev  = spi_cs_n;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int n = 0; n < 5000; n++) begin
      bus_read(3'd0, v);
      if (!v[10]) break;
    end
  endtask

  task automatic start_burst(input int burst, input int tx, input string req);
    logic [15:0] v;
    bus_write(3'd3, 16'(burst));
    bus_write(3'd4, 16'(tx));
    bus_write(3'd0, 16'h0403);
    bus_read(3'd0, v);
    check(v[10] == 1'b1, req, "exchange bit while busy", v[10], 1);
    check(v[1:0] == 2'b11, req, "enable/master readback", v[1:0], 3);
    wait_idle();
    bus_read(3'd0, v);
    check(v[10] == 1'b0, req, "exchange bit after burst", v[10], 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    logic [15:0] v;
    check(spi_cs_n === 1'b1, "R1", "cs_n at reset", spi_cs_n, 1);
    check(spi_sck === 1'b0, "R1", "sck at reset", spi_sck, 0);
    for (int a = 0; a < 7; a++) begin
      if (a == 1 || a == 2) continue;
      bus_read(3'(a), v);
      check(v == 16'h0, "R1", $sformatf("register %0d at reset", a), v, 0);
    end
  endtask

  task automatic t_exchange_ignored();
    logic [15:0] v;
    int f0 = cs_falls;
    bus_write(3'd3, 16'd2);
    bus_write(3'd0, 16'h0400);
    bus_read(3'd0, v);
    check(v[10] == 1'b0, "R2", "exchange without enable", v[10], 0);
    bus_write(3'd0, 16'h0401);
    repeat (20) @(negedge clk);
    check(cs_falls == f0, "R2", "cs pulses without master", cs_falls - f0, 0);
    check(spi_cs_n === 1'b1, "R2", "cs_n stays high", spi_cs_n, 1);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd0, "R2", "rx level after ignored exchange", v[6:0], 0);
  endtask

  task automatic t_command_read();
    logic [15:0] v;
    logic [7:0] cmd [4] = '{8'h03, 8'h12, 8'h34, 8'h56};
    int f0 = cs_falls;
    for (int i = 0; i < 4; i++) bus_write(3'd1, {8'h00, cmd[i]});
    start_burst(10, 4, "R2");
    check(cs_falls == f0 + 1, "R6", "one cs pulse per burst", cs_falls - f0, 1);
    check(s_nbyte == 10, "R3", "bytes clocked", s_nbyte, 10);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] e = (i < 4) ? cmd[i] : 8'hFF;
      check(cap[i] == e, "R3 R5", $sformatf("mosi byte %0d", i), cap[i], e);
    end
    check(t_first_rise - t_cs_fall >= 9.9, "R6", "cs lead time (ps)",
          int'((t_first_rise - t_cs_fall) * 1000), 10000);
    check(t_cs_rise > t_last_fall, "R6", "cs rises after last fall (ps)",
          int'((t_cs_rise - t_last_fall) * 1000), 1);
    check(sck_period > 19.9 && sck_period < 20.1, "R7", "sck period div4 (ps)",
          int'(sck_period * 1000), 20000);
    check(sck_rise_no_cs == 0, "R5", "sck rises outside cs", sck_rise_no_cs, 0);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd10, "R8", "rx level", v[6:0], 10);
    check(v[14:8] == 7'd0, "R8", "tx level", v[14:8], 0);
    for (int i = 0; i < 10; i++) begin
      bus_read(3'd2, v);
      check(v[7:0] == resp(i), "R4", $sformatf("rx byte %0d", i), v[7:0], resp(i));
    end
  endtask

  task automatic t_fast_clock();
    logic [15:0] v;
    bus_write(3'd5, 16'h0001);
    bus_read(3'd5, v);
    check(v[0] == 1'b1, "R7", "clock setting readback", v[0], 1);
    start_burst(2, 0, "R7");
    check(sck_period > 9.9 && sck_period < 10.1, "R7", "sck period div2 (ps)",
          int'(sck_period * 1000), 10000);
    check(cap[0] == 8'hFF && cap[1] == 8'hFF, "R3", "all-dummy burst", {cap[0], cap[1]}, 16'hFFFF);
    bus_read(3'd2, v);
    check(v[7:0] == resp(0), "R4", "rx byte 0 at div2", v[7:0], resp(0));
    bus_read(3'd2, v);
    check(v[7:0] == resp(1), "R4", "rx byte 1 at div2", v[7:0], resp(1));
    bus_write(3'd5, 16'h0000);
  endtask

  task automatic t_tx_shortfall();
    logic [15:0] v;
    bus_write(3'd1, 16'h00A5);
    start_burst(3, 3, "R3");
    check(cap[0] == 8'hA5, "R3", "first byte from fifo", cap[0], 8'hA5);
    check(cap[1] == 8'hFF && cap[2] == 8'hFF, "R3", "dummy when fifo empty",
          {cap[1], cap[2]}, 16'hFFFF);
    bus_write(3'd0, 16'h0203);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd0, "R9", "rx flush after shortfall burst", v[6:0], 0);
  endtask

  task automatic t_flushes();
    logic [15:0] v;
    for (int i = 0; i < 5; i++) bus_write(3'd1, 16'(i));
    bus_read(3'd6, v);
    check(v[14:8] == 7'd5, "R8", "tx level after 5 writes", v[14:8], 5);
    bus_write(3'd0, 16'h0103);
    bus_read(3'd6, v);
    check(v[14:8] == 7'd0, "R9", "tx flush", v[14:8], 0);
    start_burst(2, 0, "R9");
    bus_read(3'd6, v);
    check(v[6:0] == 7'd2, "R9", "rx level before flush", v[6:0], 2);
    bus_write(3'd0, 16'h0203);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd0, "R9", "rx flush", v[6:0], 0);
    bus_read(3'd0, v);
    check(v[9:8] == 2'b00, "R9", "flush bits read 0", v[9:8], 0);
  endtask

  task automatic t_soft_reset();
    logic [15:0] v;
    for (int i = 0; i < 3; i++) bus_write(3'd1, 16'h0011);
    bus_write(3'd3, 16'd7);
    bus_write(3'd4, 16'd2);
    bus_write(3'd0, 16'h8003);
    bus_read(3'd0, v);
    check(v[15] == 1'b0, "R10", "soft reset self-clears", v[15], 0);
    bus_read(3'd3, v);
    check(v == 16'h0, "R10", "burst count cleared", v, 0);
    bus_read(3'd4, v);
    check(v == 16'h0, "R10", "transmit count cleared", v, 0);
    bus_read(3'd6, v);
    check(v == 16'h0, "R10", "fifo levels cleared", v, 0);
  endtask

  task automatic t_full_and_empty();
    logic [15:0] v;
    for (int i = 0; i < 65; i++) bus_write(3'd1, 16'(i + 8'h40));
    bus_read(3'd6, v);
    check(v[14:8] == 7'd64, "R11", "tx level stays at 64", v[14:8], 64);
    start_burst(64, 64, "R8");
    for (int i = 0; i < 64; i++)
      check(cap[i] == 8'(i + 8'h40), "R11", $sformatf("mosi byte %0d", i), cap[i], i + 8'h40);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd64, "R8", "rx level full", v[6:0], 64);
    for (int i = 0; i < 64; i++) begin
      bus_read(3'd2, v);
      check(v[7:0] == resp(i), "R4", $sformatf("rx byte %0d of 64", i), v[7:0], resp(i));
    end
    bus_read(3'd2, v);
    check(v == 16'h0, "R11", "empty rx read", v, 0);
    bus_read(3'd6, v);
    check(v[6:0] == 7'd0, "R11", "rx level after empty read", v[6:0], 0);
  endtask

  // ---------------- run ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_exchange_ignored();
    t_command_read();
    t_fast_clock();
    t_tx_shortfall();
    t_flushes();
    t_soft_reset();
    t_full_and_empty();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule